// File: doc/BRIEF.md
# Watchdog and Reset Pulse Generator

This block is the digital core of a processor supervisor. It holds the processor in reset while a low-supply flag is raised, and keeps reset asserted for a fixed settling time after the flag drops. That time lets the processor's clock oscillator start before code runs. The same timing applies at power-up. Reset is driven on two complementary pins, one active-low and one active-high.

Software proves it is alive by toggling a strobe line. If the watchdog is enabled and no strobe edge arrives within the selected timeout, the block issues a fixed-width reset pulse and drives a latched fault output low. While the strobe stays idle, the block issues a new pulse after every further timeout. The fault output stays low until a strobe edge is seen while reset is released. All lengths are derived from a clock-rate parameter and millisecond parameters. A one-bit timebase select chooses between a long timeout and a short timeout.

Top module: `wdog_reset_gen`

## Requirements
- R1: While `low_supply` is high, `reset_o` stays high. Let edge k be the first clock edge that samples `low_supply` low. `reset_o` then falls at the (RST_CYC+1)-th edge after edge k. This covers two synchronizer stages plus RST_CYC-1 edges of settling count.
- R2: `reset_n_o` is always the inverse of `reset_o`. While `rst_n` is low, `reset_o` is 1, `reset_n_o` is 0 and `wd_fault_n` is 1.
- R3: At power-up, the synchronizer treats the supply as low. With `low_supply` low, `reset_o` therefore falls at the (RST_CYC+1)-th edge after the first edge with `rst_n` high.
- R4: With `wd_en` high and reset released, each clock edge without a strobe edge advances the timeout count. At the TIMEOUT-th such edge, `reset_o` goes high for exactly RST_CYC cycles and `wd_fault_n` goes low.
- R5: While the strobe stays idle, pulses repeat. Each pulse is RST_CYC cycles high, and each gap between pulses is TIMEOUT cycles low. The count restarts from zero when a pulse ends.
- R6: A rising or a falling strobe edge restarts the count. When the strobe toggles at intervals shorter than TIMEOUT-2 cycles, no pulse occurs and `wd_fault_n` stays 1. If the strobe then stops, the pulse begins TIMEOUT+2 cycles after the last toggle.
- R7: A strobe edge while `reset_o` is high does not clear the fault. A strobe edge while `reset_o` is low sets `wd_fault_n` back to 1 within three cycles.
- R8: While `wd_en` is low, no watchdog pulse occurs and `wd_fault_n` is 1.
- R9: `tb_sel`=0 selects TIMEOUT = TOUT_LONG_MS×CLK_KHZ cycles. `tb_sel`=1 selects TIMEOUT = TOUT_SHORT_MS×CLK_KHZ cycles. RST_CYC = RST_MS×CLK_KHZ.
- R10: A raised `low_supply` forces `wd_fault_n` to 1 within four cycles, even while faulted, and clears the timeout count. After release, the first gap is a full TIMEOUT.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous flop reset, active low |
| low_supply | input | 1 | Low-supply flag, asynchronous |
| wd_strobe | input | 1 | Software strobe, asynchronous; any edge is service |
| wd_en | input | 1 | Watchdog enable |
| tb_sel | input | 1 | Timeout select: 0 long, 1 short |
| reset_n_o | output | 1 | Processor reset, active low |
| reset_o | output | 1 | Processor reset, active high |
| wd_fault_n | output | 1 | Latched watchdog fault, active low |

## Verification
A timeout count that runs early, late or during reset shows on `reset_o` as a wrong gap length. The bench therefore measures every low and every high run to the exact cycle, and an off-by-one shows in the first pulse after release. A fault latch that clears during a pulse, or fails to clear on service, shows on `wd_fault_n` within three cycles of the strobe edge. A synchronizer with a missing or extra stage shifts the release after a low-supply drop by one cycle.

// File: rtl/wdr_pkg.sv
package wdr_pkg;
  // cycles in a span of milliseconds at a clock given in kHz
  function automatic int unsigned ms_cycles(input int unsigned khz, input int unsigned ms);
    return khz * ms;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wdr_sync.sv
module wdr_sync #(
  parameter int unsigned WIDTH = 2,
  parameter logic [WIDTH-1:0] INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta[i] <= INIT[i];
        q[i]    <= INIT[i];
      end else begin
        meta[i] <= d[i];
        q[i]    <= meta[i];
      end
    end
  end
endmodule

// File: rtl/wdr_rst_timer.sv
module wdr_rst_timer #(
  parameter int unsigned RST_CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_s,
  input  logic trip,
  output logic rst_q
);
  localparam int unsigned RW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [RW-1:0] LAST = RW'(RST_CYC - 1);

  logic [RW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q <= 1'b1;
      cnt   <= '0;
    end else if (low_s || trip) begin
      rst_q <= 1'b1;
      cnt   <= '0;
    end else if (rst_q) begin
      if (cnt == LAST) begin
        rst_q <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdr_timeout.sv
module wdr_timeout #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold,
  input  logic          kick,
  input  logic [CW-1:0] limit,
  output logic          trip,
  output logic [CW-1:0] count
);
  assign trip = !hold && !kick && (count == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count <= '0;
    else if (hold || kick || trip) count <= '0;
    else                        count <= count + 1'b1;
  end
endmodule

// File: rtl/wdog_reset_gen.sv
module wdog_reset_gen #(
  parameter int unsigned CLK_KHZ       = 1000,
  parameter int unsigned RST_MS        = 50,
  parameter int unsigned TOUT_LONG_MS  = 1600,
  parameter int unsigned TOUT_SHORT_MS = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic low_supply,
  input  logic wd_strobe,
  input  logic wd_en,
  input  logic tb_sel,
  output logic reset_n_o,
  output logic reset_o,
  output logic wd_fault_n
);
  import wdr_pkg::*;

  localparam int unsigned RST_CYC  = ms_cycles(CLK_KHZ, RST_MS);
  localparam int unsigned T_LONG   = ms_cycles(CLK_KHZ, TOUT_LONG_MS);
  localparam int unsigned T_SHORT  = ms_cycles(CLK_KHZ, TOUT_SHORT_MS);
  localparam int unsigned CW       = $clog2(max2(T_LONG, T_SHORT) + 1);

  logic [1:0]    sync_q;
  logic          low_s, strobe_s, strobe_d;
  logic          strobe_edge, wd_trip, wd_hold, rst_q;
  logic [CW-1:0] limit, wd_count;

  // bit 0: supply flag (reset to "low supply"), bit 1: strobe
  wdr_sync #(.WIDTH(2), .INIT(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({wd_strobe, low_supply}), .q(sync_q)
  );
  assign low_s    = sync_q[0];
  assign strobe_s = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_d <= 1'b0;
    else        strobe_d <= strobe_s;
  end
  assign strobe_edge = strobe_s ^ strobe_d;

  assign limit   = tb_sel ? CW'(T_SHORT) : CW'(T_LONG);
  assign wd_hold = low_s || !wd_en || rst_q;

  wdr_timeout #(.CW(CW)) u_tout (
    .clk(clk), .rst_n(rst_n), .hold(wd_hold), .kick(strobe_edge),
    .limit(limit), .trip(wd_trip), .count(wd_count)
  );

  wdr_rst_timer #(.RST_CYC(RST_CYC)) u_rtim (
    .clk(clk), .rst_n(rst_n), .low_s(low_s), .trip(wd_trip), .rst_q(rst_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          wd_fault_n <= 1'b1;
    else if (low_s || !wd_en)            wd_fault_n <= 1'b1;
    else if (wd_trip)                    wd_fault_n <= 1'b0;
    else if (strobe_edge && !rst_q)      wd_fault_n <= 1'b1;
  end

  assign reset_o   = rst_q;
  assign reset_n_o = !rst_q;
endmodule

// File: rtl/wdog_reset_gen_chk.sv
module wdog_reset_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic low_s,
  input logic strobe_edge,
  input logic wd_trip,
  input logic wd_en,
  input logic reset_o,
  input logic reset_n_o,
  input logic wd_fault_n
);
  assert_complement_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reset_o != reset_n_o);

  assert_low_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    low_s |=> reset_o);

  assert_trip_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_trip |=> (reset_o && !wd_fault_n));

  assert_fault_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_fault_n && low_s == 1'b0 && wd_en && !(strobe_edge && !reset_o)) |=> !wd_fault_n);

  assert_no_trip_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |-> !wd_trip);

  assert_low_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    low_s |=> wd_fault_n);
endmodule

bind wdog_reset_gen wdog_reset_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .low_s(low_s), .strobe_edge(strobe_edge),
  .wd_trip(wd_trip), .wd_en(wd_en), .reset_o(reset_o),
  .reset_n_o(reset_n_o), .wd_fault_n(wd_fault_n)
);

// File: tb/wdog_reset_gen_tb.sv
`timescale 1ns/1ps
module wdog_reset_gen_tb;
  localparam int unsigned KHZ = 1;
  localparam int RST  = 20 * KHZ;
  localparam int TL   = 1600 * KHZ;
  localparam int TS   = 200 * KHZ;

  logic clk = 1'b0;
  logic rst_n, low_supply, wd_strobe, wd_en, tb_sel;
  logic reset_n_o, reset_o, wd_fault_n;
  int checks = 0, fails = 0;
  int n;

  always #2.5 clk = ~clk;

  wdog_reset_gen #(.CLK_KHZ(KHZ), .RST_MS(20), .TOUT_LONG_MS(1600), .TOUT_SHORT_MS(200)) u_dut (
    .clk(clk), .rst_n(rst_n), .low_supply(low_supply), .wd_strobe(wd_strobe),
    .wd_en(wd_en), .tb_sel(tb_sel), .reset_n_o(reset_n_o), .reset_o(reset_o),
    .wd_fault_n(wd_fault_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts samples equal to lvl, starting with the current one
  task automatic run_len(input logic lvl, output int len);
    len = 0;
    while (reset_o === lvl && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state;
    repeat (3) @(negedge clk);
    chk("R2 reset_o in reset", reset_o, 1);
    chk("R2 reset_n_o in reset", reset_n_o, 0);
    chk("R2 fault_n in reset", wd_fault_n, 1);
  endtask

  task automatic t_powerup;
    low_supply = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    run_len(1'b1, n);
    chk("R3 power-up release", n, RST + 1);
    chk("R2 complement", reset_n_o, 1);
  endtask

  task automatic t_disabled;
    int bad = 0;
    repeat (2 * TS + 50) begin
      @(negedge clk);
      if (reset_o !== 1'b0 || wd_fault_n !== 1'b1) bad++;
    end
    chk("R8 disabled no pulse", bad, 0);
  endtask

  task automatic t_timeout_short;
    wd_en = 1'b1;
    @(negedge clk);
    run_len(1'b0, n);
    chk("R4 R9 first gap from enable", n, TS - 1);
    chk("R4 fault low", wd_fault_n, 0);
    run_len(1'b1, n);
    chk("R4 pulse width", n, RST);
    run_len(1'b0, n);
    chk("R5 repeat gap", n, TS);
  endtask

  task automatic t_fault_in_reset;
    int bad = 0;
    wd_strobe = ~wd_strobe;
    repeat (5) begin
      @(negedge clk);
      if (wd_fault_n !== 1'b0) bad++;
    end
    chk("R7 edge in reset keeps fault", bad, 0);
    run_len(1'b1, n);
    chk("R5 repeat pulse width", n, RST - 5);
    wd_strobe = ~wd_strobe;
    repeat (3) @(negedge clk);
    chk("R7 edge after release clears fault", wd_fault_n, 1);
  endtask

  task automatic t_service_long;
    int bad = 0;
    tb_sel = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (400) begin
        @(negedge clk);
        if (reset_o !== 1'b0 || wd_fault_n !== 1'b1) bad++;
      end
      wd_strobe = ~wd_strobe;
    end
    chk("R6 serviced no pulse", bad, 0);
    @(negedge clk);
    run_len(1'b0, n);
    chk("R6 R9 long gap after last toggle", n, TL + 2);
    chk("R4 fault after long timeout", wd_fault_n, 0);
  endtask

  task automatic t_low_while_fault;
    int bad = 0;
    tb_sel = 1'b1;
    low_supply = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 low clears fault", wd_fault_n, 1);
    repeat (300) begin
      @(negedge clk);
      if (reset_o !== 1'b1) bad++;
    end
    chk("R1 reset held while low", bad, 0);
    low_supply = 1'b0;
    @(negedge clk);
    run_len(1'b1, n);
    chk("R1 release after low", n, RST + 1);
    chk("R10 fault high after release", wd_fault_n, 1);
    run_len(1'b0, n);
    chk("R10 full gap after low", n, TS);
  endtask

  task automatic t_disable_mid;
    int bad = 0;
    wd_en = 1'b0;
    repeat (2) @(negedge clk);
    chk("R8 disable clears fault", wd_fault_n, 1);
    run_len(1'b1, n);
    repeat (2 * TS + 10) begin
      @(negedge clk);
      if (reset_o !== 1'b0 || wd_fault_n !== 1'b1) bad++;
    end
    chk("R8 no pulse after disable", bad, 0);
  endtask

  initial begin
    rst_n = 1'b0; low_supply = 1'b1; wd_strobe = 1'b0; wd_en = 1'b0; tb_sel = 1'b1;
    t_reset_state();
    t_powerup();
    t_disabled();
    t_timeout_short();
    t_fault_in_reset();
    t_service_long();
    t_low_while_fault();
    t_disable_mid();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule